// File: doc/BRIEF.md
# Complementary Output Dead-Time Generator

This block turns one reference bit per channel into a pair of output pins. It is meant to sit behind a PWM compare stage. When a channel runs in complementary mode, the main pin is active while the reference is high and the complementary pin is active while it is low. At every reference transition, the output that is about to become active waits a programmable number of clock cycles first. During that gap both pins are inactive, so a half-bridge built from the two pins never conducts through both switches at once.

Two enable bits per channel pick how the reference is routed:

| Main enable | Complementary enable | Routing |
|---|---|---|
| 0 | 0 | Both pins stay idle. |
| 1 | 0 | Main pin only, carrying the reference. |
| 0 | 1 | Complementary pin only, carrying the reference non-inverted. |
| 1 | 1 | Both pins, complementary, with the dead-time gap. |

Each pin has its own polarity bit, applied after dead-time insertion, so either pin can be driven active-low. One dead-time count is shared by all channels. Each channel times its own gap with its own down-counter.

Top module: `dtg_top`

## Requirements
- R1: While reset is asserted, and before any reference has been sampled, every pin sits at its inactive level. For a pin with polarity bit 0 that level is 0; for a pin with polarity bit 1 it is 1.
- R2: With both enables set, the main pin is active while the reference has stayed high and the complementary pin is active while it has stayed low. A reference sample reaches the pins two clock cycles after the edge that captures it.
- R3: With both enables set and a dead-time count D greater than 0, the pin that goes active after a reference transition does so only when the new level has been held for D+1 consecutive samples. Until then both pins are inactive.
- R4: With both enables set, a reference pulse (high or low) lasting at most D samples leaves the pin it would have activated inactive for the whole pulse.
- R5: With both enables set and D = 0, the two pins of a channel are exact logical inverses of each other at their active levels, with no gap.
- R6: With only the complementary enable set, the complementary pin is active exactly when the reference is high (not inverted), with the two-cycle latency, and the main pin stays inactive.
- R7: With only the main enable set, the main pin is active exactly when the reference is high, with the two-cycle latency, and the complementary pin stays inactive.
- R8: With neither enable set, both pins of the channel stay at their inactive level whatever the reference does.
- R9: A polarity bit of 1 makes its pin active-low. The pin level equals the internal active flag XOR the polarity bit.
- R10: The main and complementary pins of a channel are never active in the same cycle.
- R11: The single dead-time count applies to every channel. Each channel's gap timing depends only on its own reference history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | NUM_CH | Reference waveform, one bit per channel |
| dead_cnt_i | input | DT_W | Dead-time length in clock cycles, shared by all channels |
| main_en_i | input | NUM_CH | Per-channel enable of the main pin |
| comp_en_i | input | NUM_CH | Per-channel enable of the complementary pin |
| main_pol_i | input | NUM_CH | Per-channel main pin polarity, 1 = active-low |
| comp_pol_i | input | NUM_CH | Per-channel complementary pin polarity, 1 = active-low |
| main_o | output | NUM_CH | Main output pins |
| comp_o | output | NUM_CH | Complementary output pins |

## Verification
The bench builds the block with three channels and a 4-bit dead-time count. The narrow count puts the largest gap, 15 cycles, within a few hundred cycles of stimulus, and it lets the reference model keep a 16-sample history window per channel. Three channels are enough to run one steady, one randomised and one short-pulse reference side by side under a shared dead-time. In the mixed segment, the three channels also cover the main-only, complementary-only and idle routings in the same run.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

    // Routing selected by the enable pair, encoded as {comp_en, main_en}
    typedef enum logic [1:0] {
        ROUTE_OFF  = 2'b00,
        ROUTE_MAIN = 2'b01,
        ROUTE_COMP = 2'b10,
        ROUTE_PAIR = 2'b11
    } route_e;

    function automatic route_e route_of(input logic main_en, input logic comp_en);
        return route_e'({comp_en, main_en});
    endfunction

endpackage

// File: rtl/dtg_lane.sv
// Per-channel dead-time timer: tracks the last reference sample and
// releases the newly active side only after the gap has elapsed.
module dtg_lane #(
    parameter int DT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_i,
    input  logic [DT_W-1:0] dead_i,
    output logic            ref_q_o,
    output logic            main_act_o,
    output logic            comp_act_o
);

    typedef struct packed {
        logic            ref_s;
        logic [DT_W-1:0] cnt;
        logic            main_act;
        logic            comp_act;
    } lane_t;

    lane_t lane_d, lane_q;
    logic  edge_seen;

    always_comb begin
        lane_d       = lane_q;
        edge_seen    = (ref_i != lane_q.ref_s);
        lane_d.ref_s = ref_i;
        if (edge_seen) begin
            lane_d.cnt = dead_i;
        end else if (lane_q.cnt != '0) begin
            lane_d.cnt = lane_q.cnt - 1'b1;
        end else begin
            lane_d.cnt = '0;
        end
        // a side is released only once the timer is idle
        lane_d.main_act = (lane_d.cnt == '0) &&  ref_i;
        lane_d.comp_act = (lane_d.cnt == '0) && !ref_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign ref_q_o    = lane_q.ref_s;
    assign main_act_o = lane_q.main_act;
    assign comp_act_o = lane_q.comp_act;

    // R10: the two internal active flags never coincide
    a_r10_lane_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_act_o && comp_act_o));

    // R3: a transition with a nonzero gap leaves both sides idle next cycle
    a_r3_gap_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ((ref_i != ref_q_o) && (dead_i != '0)) |=> (!main_act_o && !comp_act_o));

    // R2: with an idle timer and a steady reference, the flags track the level
    a_r2_settled_level: assert property (@(posedge clk) disable iff (!rst_n)
        ((lane_q.cnt == '0) && (ref_i == ref_q_o))
            |=> ((main_act_o == ref_q_o) && (comp_act_o == !ref_q_o)));

    // R5: zero gap with an idle timer yields exactly one active side
    a_r5_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ((dead_i == '0) && (lane_q.cnt == '0)) |=> (main_act_o != comp_act_o));

endmodule

// File: rtl/dtg_steer.sv
// Per-channel output stage: applies the enable routing in a register
// and the polarity inversion at the pin.
module dtg_steer
    import dtg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic main_en_i,
    input  logic comp_en_i,
    input  logic main_pol_i,
    input  logic comp_pol_i,
    input  logic ref_q_i,
    input  logic main_act_i,
    input  logic comp_act_i,
    output logic main_o,
    output logic comp_o
);

    typedef struct packed {
        logic m;
        logic c;
    } steer_t;

    steer_t steer_d, steer_q;
    route_e mode;

    assign mode = route_of(main_en_i, comp_en_i);

    always_comb begin
        steer_d = '0;
        unique case (mode)
            ROUTE_PAIR: begin
                steer_d.m = main_act_i;
                steer_d.c = comp_act_i;
            end
            ROUTE_MAIN: steer_d.m = ref_q_i;
            ROUTE_COMP: steer_d.c = ref_q_i;
            default:    steer_d   = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steer_q <= '0;
        end else begin
            steer_q <= steer_d;
        end
    end

    // R9: polarity is applied last
    assign main_o = steer_q.m ^ main_pol_i;
    assign comp_o = steer_q.c ^ comp_pol_i;

    // R10: pins never active together
    a_r10_pins_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((main_o ^ main_pol_i) && (comp_o ^ comp_pol_i)));

    // R8: idle routing parks both pins
    a_r8_idle_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ROUTE_OFF) |=> (!steer_q.m && !steer_q.c));

    // R6: lone complementary enable passes the reference non-inverted
    a_r6_comp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ROUTE_COMP) |=> ((steer_q.c == $past(ref_q_i)) && !steer_q.m));

    // R7: lone main enable passes the reference
    a_r7_main_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == ROUTE_MAIN) |=> ((steer_q.m == $past(ref_q_i)) && !steer_q.c));

endmodule

// File: rtl/dtg_top.sv
module dtg_top #(
    parameter int NUM_CH = 4,
    parameter int DT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ref_i,
    input  logic [DT_W-1:0]   dead_cnt_i,
    input  logic [NUM_CH-1:0] main_en_i,
    input  logic [NUM_CH-1:0] comp_en_i,
    input  logic [NUM_CH-1:0] main_pol_i,
    input  logic [NUM_CH-1:0] comp_pol_i,
    output logic [NUM_CH-1:0] main_o,
    output logic [NUM_CH-1:0] comp_o
);

    logic [NUM_CH-1:0] ref_q;
    logic [NUM_CH-1:0] main_act;
    logic [NUM_CH-1:0] comp_act;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dtg_lane #(
            .DT_W (DT_W)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .ref_i      (ref_i[ch]),
            .dead_i     (dead_cnt_i),
            .ref_q_o    (ref_q[ch]),
            .main_act_o (main_act[ch]),
            .comp_act_o (comp_act[ch])
        );

        dtg_steer u_steer (
            .clk        (clk),
            .rst_n      (rst_n),
            .main_en_i  (main_en_i[ch]),
            .comp_en_i  (comp_en_i[ch]),
            .main_pol_i (main_pol_i[ch]),
            .comp_pol_i (comp_pol_i[ch]),
            .ref_q_i    (ref_q[ch]),
            .main_act_i (main_act[ch]),
            .comp_act_i (comp_act[ch]),
            .main_o     (main_o[ch]),
            .comp_o     (comp_o[ch])
        );
    end

    // R1: reset parks every pin at its polarity level
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> ((main_o == main_pol_i) && (comp_o == comp_pol_i)));

endmodule

// File: tb/dtg_top_bench.sv
`timescale 1ns/1ps
module dtg_top_bench;

    localparam int NUM_CH = 3;
    localparam int DT_W   = 4;
    localparam int HIST   = 1 << DT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_CH-1:0] ref_i = '0;
    logic [DT_W-1:0]   dead_cnt_i = '0;
    logic [NUM_CH-1:0] main_en_i = '0;
    logic [NUM_CH-1:0] comp_en_i = '0;
    logic [NUM_CH-1:0] main_pol_i = '0;
    logic [NUM_CH-1:0] comp_pol_i = '0;
    logic [NUM_CH-1:0] main_o;
    logic [NUM_CH-1:0] comp_o;

    always #2.5 clk = ~clk;

    dtg_top #(.NUM_CH(NUM_CH), .DT_W(DT_W)) u_dtg_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_i),
        .dead_cnt_i (dead_cnt_i),
        .main_en_i  (main_en_i),
        .comp_en_i  (comp_en_i),
        .main_pol_i (main_pol_i),
        .comp_pol_i (comp_pol_i),
        .main_o     (main_o),
        .comp_o     (comp_o)
    );

    typedef struct {
        logic [NUM_CH-1:0] m;
        logic [NUM_CH-1:0] c;
        string             tag;
    } exp_t;

    exp_t           exp_q[$];
    logic [HIST-1:0] hist [NUM_CH];
    logic [15:0]    lfsr = 16'hACE1;
    int             n_checks = 0;
    int             n_fail   = 0;
    bit             done     = 1'b0;

    // Monitor: compares pins against the item pushed two cycles earlier
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() == 2) begin
                exp_t e;
                e = exp_q.pop_front();
                for (int ch = 0; ch < NUM_CH; ch++) begin
                    n_checks++;
                    if (main_o[ch] !== e.m[ch] || comp_o[ch] !== e.c[ch]) begin
                        n_fail++;
                        $display("FAIL %s ch%0d: main/comp actual %b%b expected %b%b",
                                 e.tag, ch, main_o[ch], comp_o[ch], e.m[ch], e.c[ch]);
                    end
                    // R10: never both active
                    n_checks++;
                    if ((main_o[ch] ^ main_pol_i[ch]) && (comp_o[ch] ^ comp_pol_i[ch])) begin
                        n_fail++;
                        $display("FAIL R10 ch%0d: both active, actual %b%b expected not both",
                                 ch, main_o[ch], comp_o[ch]);
                    end
                end
            end
        end
    end

    function automatic logic gen_ref(int seg, int ch, int t, logic lb);
        case (ch)
            0:       return lb;
            1:       return ((t % 12) < (1 + (t / 12) % 5));
            default: return ((t / (9 + seg * 8)) % 2) == 1;
        endcase
    endfunction

    // Driver: applies one segment and pushes the expected pins per cycle
    task automatic run_seg(int seg, int dt, logic [NUM_CH-1:0] men, logic [NUM_CH-1:0] cen,
                           logic [NUM_CH-1:0] pm, logic [NUM_CH-1:0] pc, int ncyc, string tag);
        @(negedge clk);
        rst_n      = 1'b0;
        ref_i      = '0;
        dead_cnt_i = DT_W'(dt);
        main_en_i  = men;
        comp_en_i  = cen;
        main_pol_i = pm;
        comp_pol_i = pc;
        exp_q.delete();
        for (int ch = 0; ch < NUM_CH; ch++) hist[ch] = '0;
        @(negedge clk);
        @(negedge clk);
        // R1: pins idle at their polarity level during reset
        n_checks++;
        if (main_o !== pm || comp_o !== pc) begin
            n_fail++;
            $display("FAIL R1 reset: actual %b/%b expected %b/%b", main_o, comp_o, pm, pc);
        end
        rst_n = 1'b1;
        for (int t = 0; t < ncyc; t++) begin
            exp_t e;
            if (t != 0) @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            for (int ch = 0; ch < NUM_CH; ch++) begin
                logic r, allhi, alllo, am, ac;
                r = gen_ref(seg, ch, t, lfsr[0]);
                ref_i[ch] = r;
                hist[ch] = {hist[ch][HIST-2:0], r};
                allhi = 1'b1;
                alllo = 1'b1;
                for (int i = 0; i <= dt; i++) begin
                    if (hist[ch][i]) alllo = 1'b0;
                    else             allhi = 1'b0;
                end
                case ({cen[ch], men[ch]})
                    2'b11:   begin am = allhi;       ac = alllo;       end
                    2'b01:   begin am = hist[ch][0]; ac = 1'b0;        end
                    2'b10:   begin am = 1'b0;        ac = hist[ch][0]; end
                    default: begin am = 1'b0;        ac = 1'b0;        end
                endcase
                e.m[ch] = am ^ pm[ch];
                e.c[ch] = ac ^ pc[ch];
            end
            e.tag = tag;
            exp_q.push_back(e);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // R2 R3 R4 R11: paired, gap 3, pulses shorter and longer than the gap
        run_seg(0, 3, 3'b111, 3'b111, 3'b000, 3'b000, 300, "R2 R3 R4 R11");
        // R5 R9: zero gap with mixed polarities
        run_seg(1, 0, 3'b111, 3'b111, 3'b101, 3'b010, 200, "R5 R9");
        // R3 R4: largest gap
        run_seg(2, 15, 3'b111, 3'b111, 3'b000, 3'b000, 400, "R3 R4");
        // R6 R7 R8 R9: ch0 main only, ch1 comp only, ch2 idle
        run_seg(3, 5, 3'b001, 3'b010, 3'b110, 3'b011, 200, "R6 R7 R8 R9");
        // R9 R10: all active-low, gap 2
        run_seg(4, 2, 3'b111, 3'b111, 3'b111, 3'b111, 200, "R9 R10");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule